// File: doc/BRIEF.md
# Partial-Refresh Update Sequencer for a Grayscale E-Paper Panel

This block turns one dirty rectangle of a 4-bit grayscale framebuffer into the complete stream of controller operations that uploads the region and starts a panel refresh. It hands each operation to a downstream command framer through a valid/ready request port. It also reads packed pixel bytes, two pixels per byte, from a framebuffer read port with one cycle of latency.

A request is a one-cycle `start` with corners `(x0, y0)` inclusive and `(x1, y1)` exclusive, plus a mode select. The block first polls the refresh engine's status register until it reads zero. It then programs the image buffer address and widens the region horizontally to 4-pixel boundaries. Next it opens an image load, streams the rows, and closes the load. Last, it issues the refresh command, with its coordinates turned by 90 degrees to match the panel's native orientation.

Top module: `pd_update_seq`

## Requirements
- R1: After a synchronous active-high reset, `busy`, `done` and `fr_valid` are all low.
- R2: A rectangle with `x1 <= x0` or `y1 <= y0` produces no request at all, and `done` goes high for one cycle in the cycle after `start`.
- R3: Every upload begins with a status poll: CMD 0x0010, WR 0x1224, RD. A nonzero read response repeats the whole poll, and a zero response moves on. Operation kinds on `fr_kind` are 0 = command, 1 = write word, 2 = read word, 3 = pixel byte.
- R4: After the poll, the buffer address `IMG_ADDR` is written as two register writes: CMD 0x0011, WR 0x020A, WR high half; then CMD 0x0011, WR 0x0208, WR low half.
- R5: The aligned left edge is `ax0 = x0 & ~3`. The aligned right edge is `ax1 = (x1 + 3) & ~3`. The width is `w = ax1 - ax0` and the row count is `h = y1 - y0`.
- R6: The load opens with CMD 0x0021, then the words 0x0121 (format), `ax0`, `y0`, `w`, `h`.
- R7: Then `h` rows follow, each of `w/2` pixel-byte operations carried in `fr_word[7:0]`. Row `r`, byte `c` is read from address `FB_BASE + (y0 + r) * FB_STRIDE + ax0/2 + c`, in order of increasing address within a row.
- R8: After the last pixel byte, CMD 0x0022 closes the load.
- R9: Then CMD 0x0034 is followed by the words `y0`, `PANEL_H - ax1`, `h`, `w` and the mode: 2 when `fast` was low at `start`, 6 when high.
- R10: `done` is a one-cycle pulse in the cycle after the final mode word is accepted. `busy` is high from the cycle after an accepted `start` until `done`.
- R11: While `fr_valid` is high and `fr_ready` low, `fr_kind` and `fr_word` hold steady.
- R12: A `start` that arrives while `busy` is high is ignored; the running sequence is unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | One-cycle request to upload a rectangle |
| fast | input | 1 | Selects the quick refresh mode |
| x0 | input | 12 | Left edge, inclusive |
| y0 | input | 12 | Top edge, inclusive |
| x1 | input | 12 | Right edge, exclusive |
| y1 | input | 12 | Bottom edge, exclusive |
| busy | output | 1 | Sequence in progress |
| done | output | 1 | One-cycle completion pulse |
| fr_valid | output | 1 | Operation offered to the framer |
| fr_ready | input | 1 | Framer accepts the operation |
| fr_kind | output | 2 | Operation kind (see R3) |
| fr_word | output | 16 | Command code, data word or pixel byte |
| rsp_valid | input | 1 | Read response present |
| rsp_word | input | 16 | Read response data |
| fb_rd | output | 1 | Framebuffer read strobe |
| fb_addr | output | 21 | Framebuffer byte address |
| fb_data | input | 8 | Read data, one cycle after `fb_rd` |

## Verification
Every operation is recorded in the cycle where `fr_valid` and `fr_ready` are both high. The record is taken at the falling edge, after the ready value for the next rising edge has been set, so each record matches exactly one transfer. `done` is due one cycle after the last accepted word, and for an empty rectangle one cycle after `start`; the bench compares the cycle stamps of those events directly. The status response is returned two cycles after the read is accepted, and the design must wait for it whatever that delay is. A few idle cycles after each `done` confirm that no stray traffic and no second pulse follow.

// File: rtl/pd_pkg.sv
package pd_pkg;

    localparam int CW = 12;

    typedef logic [CW-1:0] coord_t;

    typedef enum logic [1:0] {
        OP_CMD = 2'd0,
        OP_WR  = 2'd1,
        OP_RD  = 2'd2,
        OP_PIX = 2'd3
    } op_kind_e;

    typedef enum logic [1:0] {
        S_IDLE,
        S_RUN,
        S_WAIT,
        S_PIX
    } seq_state_e;

    localparam logic [15:0] CMD_REG_RD     = 16'h0010;
    localparam logic [15:0] CMD_REG_WR     = 16'h0011;
    localparam logic [15:0] CMD_LOAD_OPEN  = 16'h0021;
    localparam logic [15:0] CMD_LOAD_CLOSE = 16'h0022;
    localparam logic [15:0] CMD_SHOW       = 16'h0034;
    localparam logic [15:0] REG_ENG_STAT   = 16'h1224;
    localparam logic [15:0] REG_BUF_HI     = 16'h020A;
    localparam logic [15:0] REG_BUF_LO     = 16'h0208;
    localparam logic [15:0] LOAD_FORMAT    = 16'h0121;
    localparam logic [15:0] MODE_QUALITY   = 16'd2;
    localparam logic [15:0] MODE_QUICK     = 16'd6;

    // script positions
    localparam logic [4:0] ST_POLL_RD   = 5'd2;
    localparam logic [4:0] ST_AFTER_POL = 5'd3;
    localparam logic [4:0] ST_LAST_HDR  = 5'd14;
    localparam logic [4:0] ST_CLOSE     = 5'd15;
    localparam logic [4:0] ST_LAST      = 5'd21;

    typedef struct packed {
        coord_t ax0;
        coord_t ax1;
        coord_t y0;
        coord_t rows;
        coord_t wpix;
        coord_t bpr;
        logic   empty;
    } geom_t;

    function automatic coord_t floor4(coord_t v);
        return {v[CW-1:2], 2'b00};
    endfunction

    function automatic coord_t ceil4(coord_t v);
        coord_t t;
        t = v + coord_t'(3);
        return {t[CW-1:2], 2'b00};
    endfunction

    function automatic op_kind_e step_kind(logic [4:0] s);
        case (s)
            5'd0, 5'd3, 5'd6, 5'd9, 5'd15, 5'd16: return OP_CMD;
            5'd2:                                 return OP_RD;
            default:                              return OP_WR;
        endcase
    endfunction

endpackage

// File: rtl/pd_region_align.sv
module pd_region_align
    import pd_pkg::*;
(
    input  coord_t x0,
    input  coord_t y0,
    input  coord_t x1,
    input  coord_t y1,
    output geom_t  g
);

    always_comb begin
        g.empty = (x1 <= x0) || (y1 <= y0);
        g.ax0   = floor4(x0);
        g.ax1   = ceil4(x1);
        g.y0    = y0;
        g.rows  = y1 - y0;
        g.wpix  = g.ax1 - g.ax0;
        g.bpr   = {1'b0, g.wpix[CW-1:1]};
    end

endmodule

// File: rtl/pd_row_streamer.sv
module pd_row_streamer
    import pd_pkg::*;
#(
    parameter int          AW        = 21,
    parameter logic [AW-1:0] FB_BASE = '0,
    parameter int          FB_STRIDE = 702
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          go,
    input  coord_t        col0,
    input  coord_t        y0,
    input  coord_t        bpr,
    input  coord_t        rows,
    output logic          fb_rd,
    output logic [AW-1:0] fb_addr,
    input  logic [7:0]    fb_data,
    output logic          out_valid,
    output logic [7:0]    out_byte,
    output logic          out_last,
    input  logic          out_ready
);

    typedef enum logic [1:0] {F_IDLE, F_REQ, F_WAIT, F_OFFER} fst_e;

    localparam logic [AW-1:0] STRIDE_A = AW'(FB_STRIDE);

    fst_e          st;
    logic [AW-1:0] row_base;
    coord_t        col_cnt;
    coord_t        row_cnt;
    coord_t        bpr_q;
    coord_t        rows_q;
    logic [7:0]    byte_q;
    logic          row_end;

    assign row_end   = (col_cnt == bpr_q - coord_t'(1));
    assign fb_rd     = (st == F_REQ);
    assign fb_addr   = row_base + AW'(col_cnt);
    assign out_valid = (st == F_OFFER);
    assign out_byte  = byte_q;
    assign out_last  = (st == F_OFFER) && row_end && (row_cnt == rows_q - coord_t'(1));

    always_ff @(posedge clk) begin
        if (rst) begin
            st       <= F_IDLE;
            row_base <= '0;
            col_cnt  <= '0;
            row_cnt  <= '0;
            bpr_q    <= '0;
            rows_q   <= '0;
            byte_q   <= '0;
        end else begin
            case (st)
                F_IDLE: if (go) begin
                    row_base <= FB_BASE + AW'(y0) * STRIDE_A + AW'(col0);
                    col_cnt  <= '0;
                    row_cnt  <= '0;
                    bpr_q    <= bpr;
                    rows_q   <= rows;
                    st       <= F_REQ;
                end
                F_REQ:  st <= F_WAIT;
                F_WAIT: begin
                    byte_q <= fb_data;
                    st     <= F_OFFER;
                end
                F_OFFER: if (out_ready) begin
                    if (out_last) begin
                        st <= F_IDLE;
                    end else if (row_end) begin
                        col_cnt  <= '0;
                        row_cnt  <= row_cnt + coord_t'(1);
                        row_base <= row_base + STRIDE_A;
                        st       <= F_REQ;
                    end else begin
                        col_cnt <= col_cnt + coord_t'(1);
                        st      <= F_REQ;
                    end
                end
                default: st <= F_IDLE;
            endcase
        end
    end

    // R7: each byte is fetched once, never on back-to-back cycles
    a_r7_single_fetch: assert property (@(posedge clk) disable iff (rst)
        fb_rd |=> !fb_rd);

    // R7: reads never fall below the framebuffer base
    a_r7_addr_floor: assert property (@(posedge clk) disable iff (rst)
        fb_rd |-> (fb_addr >= FB_BASE));

    // R11: an offered byte stays put until taken
    a_r11_byte_hold: assert property (@(posedge clk) disable iff (rst)
        (out_valid && !out_ready) |=> (out_valid && $stable(out_byte)));

endmodule

// File: rtl/pd_update_seq.sv
module pd_update_seq
    import pd_pkg::*;
#(
    parameter int            PANEL_H   = 1404,
    parameter int            AW        = 21,
    parameter int            FB_STRIDE = 702,
    parameter logic [AW-1:0] FB_BASE   = 21'h001000,
    parameter logic [31:0]   IMG_ADDR  = 32'h001A_2B40
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          start,
    input  logic          fast,
    input  logic [11:0]   x0,
    input  logic [11:0]   y0,
    input  logic [11:0]   x1,
    input  logic [11:0]   y1,
    output logic          busy,
    output logic          done,
    output logic          fr_valid,
    input  logic          fr_ready,
    output logic [1:0]    fr_kind,
    output logic [15:0]   fr_word,
    input  logic          rsp_valid,
    input  logic [15:0]   rsp_word,
    output logic          fb_rd,
    output logic [AW-1:0] fb_addr,
    input  logic [7:0]    fb_data
);

    localparam logic [15:0] PANEL_H_W = 16'(PANEL_H);

    seq_state_e state;
    logic [4:0] step;
    geom_t      g_in;
    geom_t      g_q;
    logic       mode_q;
    logic       pix_go;
    logic       pix_valid;
    logic       pix_last;
    logic [7:0] pix_byte;
    logic [15:0] script_word;

    pd_region_align u_align (
        .x0 (x0),
        .y0 (y0),
        .x1 (x1),
        .y1 (y1),
        .g  (g_in)
    );

    assign pix_go = (state == S_RUN) && (step == ST_LAST_HDR) && fr_ready;

    pd_row_streamer #(
        .AW        (AW),
        .FB_BASE   (FB_BASE),
        .FB_STRIDE (FB_STRIDE)
    ) u_rows (
        .clk       (clk),
        .rst       (rst),
        .go        (pix_go),
        .col0      ({1'b0, g_q.ax0[CW-1:1]}),
        .y0        (g_q.y0),
        .bpr       (g_q.bpr),
        .rows      (g_q.rows),
        .fb_rd     (fb_rd),
        .fb_addr   (fb_addr),
        .fb_data   (fb_data),
        .out_valid (pix_valid),
        .out_byte  (pix_byte),
        .out_last  (pix_last),
        .out_ready (fr_ready && (state == S_PIX))
    );

    always_comb begin
        case (step)
            5'd0:        script_word = CMD_REG_RD;
            5'd1:        script_word = REG_ENG_STAT;
            5'd3, 5'd6:  script_word = CMD_REG_WR;
            5'd4:        script_word = REG_BUF_HI;
            5'd5:        script_word = IMG_ADDR[31:16];
            5'd7:        script_word = REG_BUF_LO;
            5'd8:        script_word = IMG_ADDR[15:0];
            5'd9:        script_word = CMD_LOAD_OPEN;
            5'd10:       script_word = LOAD_FORMAT;
            5'd11:       script_word = 16'(g_q.ax0);
            5'd12:       script_word = 16'(g_q.y0);
            5'd13:       script_word = 16'(g_q.wpix);
            5'd14:       script_word = 16'(g_q.rows);
            5'd15:       script_word = CMD_LOAD_CLOSE;
            5'd16:       script_word = CMD_SHOW;
            5'd17:       script_word = 16'(g_q.y0);
            5'd18:       script_word = PANEL_H_W - 16'(g_q.ax1);
            5'd19:       script_word = 16'(g_q.rows);
            5'd20:       script_word = 16'(g_q.wpix);
            5'd21:       script_word = mode_q ? MODE_QUICK : MODE_QUALITY;
            default:     script_word = 16'h0000;
        endcase
    end

    always_comb begin
        if (state == S_PIX) begin
            fr_valid = pix_valid;
            fr_kind  = OP_PIX;
            fr_word  = {8'h00, pix_byte};
        end else begin
            fr_valid = (state == S_RUN);
            fr_kind  = step_kind(step);
            fr_word  = script_word;
        end
    end

    assign busy = (state != S_IDLE);

    always_ff @(posedge clk) begin
        if (rst) begin
            state  <= S_IDLE;
            step   <= '0;
            done   <= 1'b0;
            g_q    <= '0;
            mode_q <= 1'b0;
        end else begin
            done <= 1'b0;
            case (state)
                S_IDLE: if (start) begin
                    if (g_in.empty) begin
                        done <= 1'b1;
                    end else begin
                        g_q    <= g_in;
                        mode_q <= fast;
                        step   <= '0;
                        state  <= S_RUN;
                    end
                end
                S_RUN: if (fr_ready) begin
                    if (step == ST_POLL_RD) begin
                        state <= S_WAIT;
                    end else if (step == ST_LAST_HDR) begin
                        step  <= ST_CLOSE;
                        state <= S_PIX;
                    end else if (step == ST_LAST) begin
                        state <= S_IDLE;
                        done  <= 1'b1;
                    end else begin
                        step <= step + 5'd1;
                    end
                end
                S_WAIT: if (rsp_valid) begin
                    step  <= (rsp_word == 16'h0000) ? ST_AFTER_POL : 5'd0;
                    state <= S_RUN;
                end
                S_PIX: if (pix_valid && fr_ready && pix_last) begin
                    state <= S_RUN;
                end
                default: state <= S_IDLE;
            endcase
        end
    end

    // R11: a stalled operation is held unchanged
    a_r11_op_hold: assert property (@(posedge clk) disable iff (rst)
        (fr_valid && !fr_ready) |=> (fr_valid && $stable(fr_kind) && $stable(fr_word)));

    // R2: an empty rectangle causes no traffic and an immediate done
    a_r2_empty_quiet: assert property (@(posedge clk) disable iff (rst)
        (!busy && start && ((x1 <= x0) || (y1 <= y0))) |=> (!fr_valid && done && !busy));

    // R10: done lasts one cycle
    a_r10_done_pulse: assert property (@(posedge clk) disable iff (rst)
        done |=> !done);

    // R10: done follows an accepted transfer or a start
    a_r10_done_cause: assert property (@(posedge clk) disable iff (rst)
        done |-> ($past(fr_valid && fr_ready) || $past(start)));

    // R5: latched region is 4-pixel aligned and nonempty
    a_r5_aligned: assert property (@(posedge clk) disable iff (rst)
        busy |-> (g_q.ax0[1:0] == 2'b00 && g_q.wpix[1:0] == 2'b00 && g_q.wpix != '0));

    // R3: no request is offered while a read response is pending
    a_r3_wait_quiet: assert property (@(posedge clk) disable iff (rst)
        (state == S_WAIT) |-> !fr_valid);

endmodule

// File: tb/sim_pd_update_seq.sv
module sim_pd_update_seq;

    localparam int            STRIDE = 702;
    localparam logic [20:0]   BASE   = 21'h001000;
    localparam logic [31:0]   IMG    = 32'h001A_2B40;
    localparam int            PH     = 1404;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        start = 1'b0;
    logic        fast = 1'b0;
    logic [11:0] x0 = '0, y0 = '0, x1 = '0, y1 = '0;
    logic        busy, done, fr_valid;
    logic        fr_ready = 1'b0;
    logic [1:0]  fr_kind;
    logic [15:0] fr_word;
    logic        rsp_valid = 1'b0;
    logic [15:0] rsp_word = '0;
    logic        fb_rd;
    logic [20:0] fb_addr;
    logic [7:0]  fb_data = '0;

    always #5 clk = ~clk;

    pd_update_seq u0 (
        .clk(clk), .rst(rst), .start(start), .fast(fast),
        .x0(x0), .y0(y0), .x1(x1), .y1(y1),
        .busy(busy), .done(done),
        .fr_valid(fr_valid), .fr_ready(fr_ready), .fr_kind(fr_kind), .fr_word(fr_word),
        .rsp_valid(rsp_valid), .rsp_word(rsp_word),
        .fb_rd(fb_rd), .fb_addr(fb_addr), .fb_data(fb_data)
    );

    function automatic logic [7:0] fbv(logic [20:0] a);
        return a[7:0] ^ a[15:8] ^ {3'b000, a[20:16]} ^ 8'h3C;
    endfunction

    always @(posedge clk) if (fb_rd) fb_data <= fbv(fb_addr);

    int n_chk = 0;
    int n_fail = 0;
    int cyc = 0;
    int nlog = 0;
    int last_log_cyc = 0;
    int done_cnt = 0;
    int done_cyc = 0;
    int polls_left = 0;
    int rsp_cd = 0;
    logic [1:0]  log_k [0:1023];
    logic [15:0] log_w [0:1023];
    int nexp = 0;
    logic [1:0]  exp_k [0:1023];
    logic [15:0] exp_w [0:1023];
    string       exp_r [0:1023];

    always @(negedge clk) begin
        cyc++;
        if (done) begin
            done_cnt++;
            done_cyc = cyc;
        end
        fr_ready = (cyc % 5) != 3;
        rsp_valid = 1'b0;
        if (rsp_cd > 0) begin
            rsp_cd--;
            if (rsp_cd == 0) begin
                rsp_valid = 1'b1;
                rsp_word = (polls_left > 0) ? 16'h0001 : 16'h0000;
                if (polls_left > 0) polls_left--;
            end
        end
        if (fr_valid && fr_ready) begin
            if (nlog < 1024) begin
                log_k[nlog] = fr_kind;
                log_w[nlog] = fr_word;
            end
            nlog++;
            last_log_cyc = cyc;
            if (fr_kind == 2'd2) rsp_cd = 2;
        end
    end

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic push(input logic [1:0] k, input logic [15:0] w, input string r);
        exp_k[nexp] = k;
        exp_w[nexp] = w;
        exp_r[nexp] = r;
        nexp++;
    endtask

    task automatic build(input int ax0, input int ax1, input int ty0, input int h,
                         input bit f, input int polls);
        int w;
        w = ax1 - ax0;
        nexp = 0;
        for (int p = 0; p <= polls; p++) begin
            push(2'd0, 16'h0010, "R3 poll cmd");
            push(2'd1, 16'h1224, "R3 poll reg");
            push(2'd2, 16'h0000, "R3 poll read");
        end
        push(2'd0, 16'h0011, "R4 wr cmd hi");
        push(2'd1, 16'h020A, "R4 hi reg");
        push(2'd1, IMG[31:16], "R4 hi val");
        push(2'd0, 16'h0011, "R4 wr cmd lo");
        push(2'd1, 16'h0208, "R4 lo reg");
        push(2'd1, IMG[15:0], "R4 lo val");
        push(2'd0, 16'h0021, "R6 open");
        push(2'd1, 16'h0121, "R6 format");
        push(2'd1, 16'(ax0), "R5 R6 x");
        push(2'd1, 16'(ty0), "R6 y");
        push(2'd1, 16'(w), "R5 R6 w");
        push(2'd1, 16'(h), "R6 h");
        for (int r = 0; r < h; r++)
            for (int c = 0; c < w / 2; c++)
                push(2'd3, {8'h00, fbv(21'(int'(BASE) + (ty0 + r) * STRIDE + ax0 / 2 + c))}, "R7 pixel");
        push(2'd0, 16'h0022, "R8 close");
        push(2'd0, 16'h0034, "R9 show");
        push(2'd1, 16'(ty0), "R9 x");
        push(2'd1, 16'(PH - ax1), "R9 y");
        push(2'd1, 16'(h), "R9 w");
        push(2'd1, 16'(w), "R9 h");
        push(2'd1, f ? 16'd6 : 16'd2, "R9 mode");
    endtask

    task automatic run_case(input int a, input int b, input int c, input int d,
                            input bit f, input int polls, input bit inject);
        int sc;
        int wd;
        bit empty;
        empty = (c <= a) || (d <= b);
        if (!empty) build(a & ~3, (c + 3) & ~3, b, d - b, f, polls);
        else nexp = 0;
        polls_left = polls;
        @(negedge clk);
        #1;
        nlog = 0;
        done_cnt = 0;
        x0 = 12'(a); y0 = 12'(b); x1 = 12'(c); y1 = 12'(d); fast = f;
        start = 1'b1;
        sc = cyc;
        @(negedge clk);
        #1;
        start = 1'b0;
        chk(busy == !empty, "R10 busy after start", int'(busy), int'(!empty));
        if (inject) begin
            repeat (8) @(negedge clk);
            #1;
            x0 = 12'd0; y0 = 12'd0; x1 = 12'd40; y1 = 12'd9; fast = ~f;
            start = 1'b1;
            @(negedge clk);
            #1;
            start = 1'b0;
        end
        wd = 0;
        while (done_cnt == 0 && wd < 20000) begin
            @(negedge clk);
            wd++;
        end
        repeat (6) @(negedge clk);
        #1;
        chk(wd < 20000, "R10 done reached", wd, 0);
        chk(done_cnt == 1, inject ? "R12 single done" : "R10 single done", done_cnt, 1);
        chk(nlog == nexp, empty ? "R2 no traffic" : "R3..R9 op count", nlog, nexp);
        if (empty)
            chk(done_cyc == sc + 1, "R2 done timing", done_cyc, sc + 1);
        else
            chk(done_cyc == last_log_cyc + 1, "R10 done timing", done_cyc, last_log_cyc + 1);
        for (int i = 0; i < nexp && i < nlog; i++) begin
            chk(log_k[i] == exp_k[i], exp_r[i], int'(log_k[i]), int'(exp_k[i]));
            chk(log_w[i] == exp_w[i], exp_r[i], int'(log_w[i]), int'(exp_w[i]));
        end
        chk(!busy && !fr_valid, "R10 idle after done", int'(busy), 0);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        #1;
        chk(busy == 1'b0, "R1 busy reset", int'(busy), 0);
        chk(done == 1'b0, "R1 done reset", int'(done), 0);
        chk(fr_valid == 1'b0, "R1 valid reset", int'(fr_valid), 0);
        rst = 1'b0;
        // R5 R7 alignment and multi-row
        run_case(5, 3, 13, 5, 1'b0, 1, 1'b0);
        run_case(0, 0, 4, 1, 1'b0, 0, 1'b0);
        run_case(7, 10, 9, 13, 1'b1, 2, 1'b0);
        // R9 edge: bottom-right corner, y word becomes zero
        run_case(1400, 1870, 1404, 1872, 1'b1, 0, 1'b0);
        // R2 empty rectangles
        run_case(8, 2, 8, 9, 1'b0, 0, 1'b0);
        run_case(3, 5, 9, 5, 1'b0, 0, 1'b0);
        run_case(10, 0, 6, 2, 1'b1, 0, 1'b0);
        // R12 start during busy
        run_case(2, 4, 11, 6, 1'b0, 1, 1'b1);
        // R5 sweep over small left edges and widths
        for (int a = 0; a < 6; a++)
            for (int len = 1; len <= 5; len++)
                run_case(a, a + 1, a + len, a + 2, 1'(len % 2), (a + len) % 3, 1'b0);
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    initial begin
        #1500000;
        n_fail++;
        $display("FAIL watchdog actual=%0d expected=%0d", cyc, 0);
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

endmodule